// File: doc/BRIEF.md
# Dual-Master Shared-Bus Address Fabric

This block joins two classic (single-beat, non-pipelined) Wishbone masters to three slaves on one chip bus. One master fetches instructions; the other issues loads and stores. The slaves are a 4 KiB program store (ROM), a 2 KiB working store (RAM) and a small window of peripheral registers. Each master's address is decoded against a fixed map. The request's cycle and strobe go only to the slave that was hit. That slave's read data and acknowledge return only to the master that owns it.

Reach is asymmetric. The instruction master can reach the ROM and nothing else. The data master can reach all three slaves. Both masters can ask for the ROM at once, so the ROM has its own arbiter. The arbiter holds the grant for the whole bus cycle of the owner. Any access that lands outside the windows its master may reach is still closed: the fabric answers it with a one-cycle acknowledge and zero read data, and it drops any write. A stray pointer or a fetch from a bad address therefore never hangs a master.

Top module: `wbx_fabric`

## Requirements
- R1: Address windows are ROM [0x20000000, 0x20001000), RAM [0x80000000, 0x80000800) and peripheral [0x40002000, 0x40002100). A data-master access inside a window reaches that slave, and the slave's read data comes back to the data master.
- R2: The instruction master reaches only the ROM. Any other address from it, including RAM and peripheral addresses, counts as unmapped. It never raises cyc or stb at the RAM or the peripheral slave.
- R3: Address, write data, byte selects and write enable reach the selected slave unchanged. Byte-select bit i enables data bits 8i+7 down to 8i.
- R4: cyc and stb are raised only at the slave the owning master's address selects. Every other slave sees both low.
- R5: An unmapped access gets an ack exactly one cycle after its strobe, with read data zero. A write to it changes no slave.
- R6: When both masters first request the ROM in the same cycle, the data master is granted first.
- R7: The ROM owner keeps the grant for as long as it holds cyc with a ROM address, across several strobes. The other master waits until then.
- R8: A master that waits for the ROM has its stb kept from the slave and sees no ack. It is granted in the same cycle the owner releases, with no idle cycle in between.
- R9: The slave's ack and read data pass to the owner without added registers. A slave that acks one cycle after the strobe gives the master an ack one cycle after its strobe.
- R10: Reset is synchronous and active low. After reset no master sees an ack, no slave sees cyc, and the ROM arbiter is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| im_adr | input | 32 | Instruction master byte address |
| im_dat_w | input | 32 | Instruction master write data |
| im_sel | input | 4 | Instruction master byte selects |
| im_we | input | 1 | Instruction master write enable |
| im_cyc | input | 1 | Instruction master cycle |
| im_stb | input | 1 | Instruction master strobe |
| im_dat_r | output | 32 | Read data to instruction master |
| im_ack | output | 1 | Acknowledge to instruction master |
| dm_adr | input | 32 | Data master byte address |
| dm_dat_w | input | 32 | Data master write data |
| dm_sel | input | 4 | Data master byte selects |
| dm_we | input | 1 | Data master write enable |
| dm_cyc | input | 1 | Data master cycle |
| dm_stb | input | 1 | Data master strobe |
| dm_dat_r | output | 32 | Read data to data master |
| dm_ack | output | 1 | Acknowledge to data master |
| rom_adr | output | 32 | ROM address |
| rom_dat_w | output | 32 | ROM write data |
| rom_sel | output | 4 | ROM byte selects |
| rom_we | output | 1 | ROM write enable |
| rom_cyc | output | 1 | ROM cycle |
| rom_stb | output | 1 | ROM strobe |
| rom_dat_r | input | 32 | ROM read data |
| rom_ack | input | 1 | ROM acknowledge |
| ram_adr | output | 32 | RAM address |
| ram_dat_w | output | 32 | RAM write data |
| ram_sel | output | 4 | RAM byte selects |
| ram_we | output | 1 | RAM write enable |
| ram_cyc | output | 1 | RAM cycle |
| ram_stb | output | 1 | RAM strobe |
| ram_dat_r | input | 32 | RAM read data |
| ram_ack | input | 1 | RAM acknowledge |
| per_adr | output | 32 | Peripheral address |
| per_dat_w | output | 32 | Peripheral write data |
| per_sel | output | 4 | Peripheral byte selects |
| per_we | output | 1 | Peripheral write enable |
| per_cyc | output | 1 | Peripheral cycle |
| per_stb | output | 1 | Peripheral strobe |
| per_dat_r | input | 32 | Peripheral read data |
| per_ack | input | 1 | Peripheral acknowledge |

## Verification
Both masters sweep the same address set: the first word, second word, last word and first word past the end of each window, plus neighbouring unmapped pages. Each address gets a write and then a read. The sweep separates correct decoding from windows that are too large or too small. The slave models alias addresses past a window onto its word 0, so a decode that lets the one-past-the-end address through overwrites word 0 and shows up. ROM contention is driven twice: once with both masters starting in the same cycle, which tests priority, and once with the instruction master holding a three-strobe cycle while the data master arrives one cycle late. The measured latencies tell a held grant apart from one that is re-arbitrated on every strobe, and they show whether the release adds an idle cycle. A partial byte-select write shows whether the byte lanes reach the slave.

// File: rtl/wbx_pkg.sv
// Package: shared types and the address-window test for the bus fabric.
// Assumes 32-bit byte addresses and power-of-two window sizes aligned to their base.
package wbx_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int NUM_MASTERS = 2;
    localparam int M_INS = 0;
    localparam int M_DAT = 1;

    // Slave a master's address selects.
    typedef enum logic [1:0] {
        TGT_MISS = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_PER  = 2'd3
    } tgt_e;

    // Current holder of the shared ROM port.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_INS  = 2'd1,
        OWN_DAT  = 2'd2
    } own_e;

    // True when adr falls in the aligned window [base, base+size).
    function automatic logic win_hit(input logic [ADDR_W-1:0] adr,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [ADDR_W-1:0] size);
        return ((adr & ~(size - 1'b1)) == base);
    endfunction

endpackage

// File: rtl/wbx_decode.sv
// Module: address decoder for one master.
// Maps an address to a target slave. Windows the master may not reach map to TGT_MISS.
// Assumes windows do not overlap.
module wbx_decode
    import wbx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ROM_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ROM_SIZE = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] RAM_BASE = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] RAM_SIZE = 32'h0000_0800,
    parameter logic [ADDR_W-1:0] PER_BASE = 32'h4000_2000,
    parameter logic [ADDR_W-1:0] PER_SIZE = 32'h0000_0100,
    parameter bit                ALLOW_WIDE = 1'b1
) (
    input  logic [ADDR_W-1:0] adr,
    output tgt_e              tgt
);

    logic hit_rom;
    logic hit_ram;
    logic hit_per;

    // Raw window matches, independent of reach.
    always_comb begin
        hit_rom = win_hit(adr, ROM_BASE, ROM_SIZE);
        hit_ram = win_hit(adr, RAM_BASE, RAM_SIZE);
        hit_per = win_hit(adr, PER_BASE, PER_SIZE);
    end

    // Reach is fixed per master, so the variant is chosen at elaboration.
    generate
        if (ALLOW_WIDE) begin : g_wide
            // Data-side reach: all three windows.
            always_comb begin
                if (hit_rom)      tgt = TGT_ROM;
                else if (hit_ram) tgt = TGT_RAM;
                else if (hit_per) tgt = TGT_PER;
                else              tgt = TGT_MISS;
            end
        end else begin : g_narrow
            // Instruction-side reach: the program store only.
            always_comb begin
                tgt = hit_rom ? TGT_ROM : TGT_MISS;
            end
            logic unused_hits;
            assign unused_hits = hit_ram ^ hit_per;
        end
    endgenerate

endmodule

// File: rtl/wbx_miss_resp.sv
// Module: responder for accesses that hit no reachable window.
// Returns a one-cycle ack one cycle after the strobe. Read data is zero, and that
// is handled by the top. Assumes the master holds stb until it sees the ack.
module wbx_miss_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc,
    input  logic stb,
    input  logic miss,
    output logic ack
);

    logic ack_q;

    // Pulse ack once per strobe; the ~ack_q term blocks a second pulse in the ack cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= cyc & stb & miss & ~ack_q;
        end
    end

    assign ack = ack_q;

endmodule

// File: rtl/wbx_rom_arb.sv
// Module: arbiter for the shared ROM port.
// The owner keeps the grant while its request stays high. A free port goes to the
// data master first. The grant is combinational, so a waiting master is granted in
// the same cycle the owner releases. Assumes a request means cyc plus a ROM address.
module wbx_rom_arb
    import wbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_ins,
    input  logic req_dat,
    output own_e gnt
);

    own_e owner_q;
    logic keep;

    // Does the registered owner still want the port?
    always_comb begin
        keep = ((owner_q == OWN_INS) && req_ins) ||
               ((owner_q == OWN_DAT) && req_dat);
    end

    // Grant: hold the owner, else fixed priority with the data master on top.
    always_comb begin
        if (keep)         gnt = owner_q;
        else if (req_dat) gnt = OWN_DAT;
        else if (req_ins) gnt = OWN_INS;
        else              gnt = OWN_NONE;
    end

    // Remember who holds the port for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_NONE;
        end else begin
            owner_q <= gnt;
        end
    end

endmodule

// File: rtl/wbx_fabric.sv
// Module: two-master, three-slave shared-bus fabric for classic single-beat transfers.
// The instruction master reaches the ROM only. The data master reaches ROM, RAM and
// the peripheral window. The ROM is arbitrated; RAM and peripheral are data-only
// pass-throughs. Unreachable addresses are answered locally. Assumes slaves return
// ack as a one-cycle pulse while cyc and stb are high.
module wbx_fabric
    import wbx_pkg::*;
#(
    parameter int unsigned       DW       = 32,
    parameter logic [ADDR_W-1:0] ROM_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ROM_SIZE = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] RAM_BASE = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] RAM_SIZE = 32'h0000_0800,
    parameter logic [ADDR_W-1:0] PER_BASE = 32'h4000_2000,
    parameter logic [ADDR_W-1:0] PER_SIZE = 32'h0000_0100,
    localparam int unsigned      SW       = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] im_adr,
    input  logic [DW-1:0]     im_dat_w,
    input  logic [SW-1:0]     im_sel,
    input  logic              im_we,
    input  logic              im_cyc,
    input  logic              im_stb,
    output logic [DW-1:0]     im_dat_r,
    output logic              im_ack,
    input  logic [ADDR_W-1:0] dm_adr,
    input  logic [DW-1:0]     dm_dat_w,
    input  logic [SW-1:0]     dm_sel,
    input  logic              dm_we,
    input  logic              dm_cyc,
    input  logic              dm_stb,
    output logic [DW-1:0]     dm_dat_r,
    output logic              dm_ack,
    output logic [ADDR_W-1:0] rom_adr,
    output logic [DW-1:0]     rom_dat_w,
    output logic [SW-1:0]     rom_sel,
    output logic              rom_we,
    output logic              rom_cyc,
    output logic              rom_stb,
    input  logic [DW-1:0]     rom_dat_r,
    input  logic              rom_ack,
    output logic [ADDR_W-1:0] ram_adr,
    output logic [DW-1:0]     ram_dat_w,
    output logic [SW-1:0]     ram_sel,
    output logic              ram_we,
    output logic              ram_cyc,
    output logic              ram_stb,
    input  logic [DW-1:0]     ram_dat_r,
    input  logic              ram_ack,
    output logic [ADDR_W-1:0] per_adr,
    output logic [DW-1:0]     per_dat_w,
    output logic [SW-1:0]     per_sel,
    output logic              per_we,
    output logic              per_cyc,
    output logic              per_stb,
    input  logic [DW-1:0]     per_dat_r,
    input  logic              per_ack
);

    logic [NUM_MASTERS-1:0] m_cyc;
    logic [NUM_MASTERS-1:0] m_stb;
    logic [NUM_MASTERS-1:0] m_miss_ack;
    logic [ADDR_W-1:0]      m_adr [NUM_MASTERS];
    tgt_e                   m_tgt [NUM_MASTERS];
    own_e                   rom_gnt;
    logic                   req_ins;
    logic                   req_dat;

    // Gather the master request lines into index-able arrays.
    always_comb begin
        m_cyc[M_INS] = im_cyc;
        m_stb[M_INS] = im_stb;
        m_adr[M_INS] = im_adr;
        m_cyc[M_DAT] = dm_cyc;
        m_stb[M_DAT] = dm_stb;
        m_adr[M_DAT] = dm_adr;
    end

    // One decoder and one miss responder per master; reach depends on the index.
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
        wbx_decode #(
            .ROM_BASE  (ROM_BASE),
            .ROM_SIZE  (ROM_SIZE),
            .RAM_BASE  (RAM_BASE),
            .RAM_SIZE  (RAM_SIZE),
            .PER_BASE  (PER_BASE),
            .PER_SIZE  (PER_SIZE),
            .ALLOW_WIDE(m == M_DAT)
        ) u_dec (
            .adr(m_adr[m]),
            .tgt(m_tgt[m])
        );

        wbx_miss_resp u_miss (
            .clk  (clk),
            .rst_n(rst_n),
            .cyc  (m_cyc[m]),
            .stb  (m_stb[m]),
            .miss (m_tgt[m] == TGT_MISS),
            .ack  (m_miss_ack[m])
        );
    end

    // ROM requests: a held cycle whose address decodes to the ROM.
    always_comb begin
        req_ins = im_cyc && (m_tgt[M_INS] == TGT_ROM);
        req_dat = dm_cyc && (m_tgt[M_DAT] == TGT_ROM);
    end

    wbx_rom_arb u_rom_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_ins(req_ins),
        .req_dat(req_dat),
        .gnt    (rom_gnt)
    );

    // ROM side: forward the granted master only; idle lines are driven low.
    always_comb begin
        rom_cyc   = 1'b0;
        rom_stb   = 1'b0;
        rom_adr   = '0;
        rom_dat_w = '0;
        rom_sel   = '0;
        rom_we    = 1'b0;
        case (rom_gnt)
            OWN_INS: begin
                rom_cyc   = 1'b1;
                rom_stb   = im_stb;
                rom_adr   = im_adr;
                rom_dat_w = im_dat_w;
                rom_sel   = im_sel;
                rom_we    = im_we;
            end
            OWN_DAT: begin
                rom_cyc   = 1'b1;
                rom_stb   = dm_stb;
                rom_adr   = dm_adr;
                rom_dat_w = dm_dat_w;
                rom_sel   = dm_sel;
                rom_we    = dm_we;
            end
            default: ;
        endcase
    end

    // RAM and peripheral sides: data master only, gated by its decode.
    always_comb begin
        ram_cyc   = dm_cyc && (m_tgt[M_DAT] == TGT_RAM);
        ram_stb   = dm_stb && (m_tgt[M_DAT] == TGT_RAM);
        ram_adr   = dm_adr;
        ram_dat_w = dm_dat_w;
        ram_sel   = dm_sel;
        ram_we    = dm_we;
        per_cyc   = dm_cyc && (m_tgt[M_DAT] == TGT_PER);
        per_stb   = dm_stb && (m_tgt[M_DAT] == TGT_PER);
        per_adr   = dm_adr;
        per_dat_w = dm_dat_w;
        per_sel   = dm_sel;
        per_we    = dm_we;
    end

    // Instruction return path: ROM response when it owns the port, else the local miss ack.
    always_comb begin
        im_ack   = m_miss_ack[M_INS] | ((rom_gnt == OWN_INS) & rom_ack);
        im_dat_r = (rom_gnt == OWN_INS) ? rom_dat_r : '0;
    end

    // Data return path: mux by the data master's own decode.
    always_comb begin
        case (m_tgt[M_DAT])
            TGT_ROM: begin
                dm_ack   = (rom_gnt == OWN_DAT) & rom_ack;
                dm_dat_r = (rom_gnt == OWN_DAT) ? rom_dat_r : '0;
            end
            TGT_RAM: begin
                dm_ack   = ram_ack;
                dm_dat_r = ram_dat_r;
            end
            TGT_PER: begin
                dm_ack   = per_ack;
                dm_dat_r = per_dat_r;
            end
            default: begin
                dm_ack   = m_miss_ack[M_DAT];
                dm_dat_r = '0;
            end
        endcase
    end

endmodule

// Module: protocol checker bound to the fabric; watches port-level rules only.
module wbx_fabric_chk #(
    parameter logic [31:0] ROM_BASE = 32'h2000_0000,
    parameter logic [31:0] ROM_SIZE = 32'h0000_1000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        im_cyc,
    input logic        im_ack,
    input logic [31:0] im_dat_r,
    input logic        dm_cyc,
    input logic [31:0] dm_adr,
    input logic        dm_ack,
    input logic [31:0] dm_dat_r,
    input logic        rom_cyc,
    input logic        rom_stb,
    input logic [31:0] rom_adr,
    input logic        ram_cyc,
    input logic        ram_stb,
    input logic        per_cyc,
    input logic        per_stb
);

    // R2: the instruction master alone never wakes RAM or peripheral.
    p_ins_reach_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (im_cyc && !dm_cyc) |-> (!ram_cyc && !per_cyc));

    // R4: a strobe at any slave lies inside a cycle at that slave.
    p_rom_stb_cyc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_stb |-> rom_cyc);
    p_ram_stb_cyc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_stb |-> ram_cyc);
    p_per_stb_cyc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_stb |-> per_cyc);

    // R5: an ack with no slave engaged is a local miss answer and reads zero.
    p_ins_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (im_ack && !rom_cyc) |-> (im_dat_r == 32'd0));
    p_dat_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_ack && !rom_cyc && !ram_cyc && !per_cyc) |-> (dm_dat_r == 32'd0));

    // R6: a free ROM port wanted by the data master goes to the data master.
    p_rom_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rom_cyc) && dm_cyc && (dm_adr >= ROM_BASE) && (dm_adr < ROM_BASE + ROM_SIZE))
        |-> (rom_cyc && (rom_adr == dm_adr)));

    // R8: no master is acked outside its own cycle.
    p_ins_ack_cyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        im_ack |-> im_cyc);
    p_dat_ack_cyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dm_ack |-> dm_cyc);

endmodule

bind wbx_fabric wbx_fabric_chk #(.ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE)) chk_i (.*);

// File: tb/wbx_fabric_tb_top.sv
// Bench: slave models, two scripted masters, sweeps over window edges and ROM contention.
module wbx_fabric_tb_top;

    localparam logic [31:0] ROM_B = 32'h2000_0000, ROM_S = 32'h1000;
    localparam logic [31:0] RAM_B = 32'h8000_0000, RAM_S = 32'h0800;
    localparam logic [31:0] PER_B = 32'h4000_2000, PER_S = 32'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int mon_r2 = 0;
    int mon_r3 = 0;
    int mon_r4 = 0;

    // Master drive arrays: index 0 instruction, 1 data.
    logic        mc  [2];
    logic        ms  [2];
    logic        mwe [2];
    logic [31:0] madr[2];
    logic [31:0] mwd [2];
    logic [3:0]  msel[2];
    logic        mack[2];
    logic [31:0] mrd [2];

    logic [31:0] im_dat_r, dm_dat_r;
    logic        im_ack, dm_ack;
    logic [31:0] rom_adr, rom_dat_w, rom_dat_r, ram_adr, ram_dat_w, ram_dat_r;
    logic [31:0] per_adr, per_dat_w, per_dat_r;
    logic [3:0]  rom_sel, ram_sel, per_sel;
    logic        rom_we, rom_cyc, rom_stb, rom_ack;
    logic        ram_we, ram_cyc, ram_stb, ram_ack;
    logic        per_we, per_cyc, per_stb, per_ack;

    assign mack[0] = im_ack;
    assign mack[1] = dm_ack;
    assign mrd[0]  = im_dat_r;
    assign mrd[1]  = dm_dat_r;

    wbx_fabric dut_i (
        .clk(clk), .rst_n(rst_n),
        .im_adr(madr[0]), .im_dat_w(mwd[0]), .im_sel(msel[0]), .im_we(mwe[0]),
        .im_cyc(mc[0]), .im_stb(ms[0]), .im_dat_r(im_dat_r), .im_ack(im_ack),
        .dm_adr(madr[1]), .dm_dat_w(mwd[1]), .dm_sel(msel[1]), .dm_we(mwe[1]),
        .dm_cyc(mc[1]), .dm_stb(ms[1]), .dm_dat_r(dm_dat_r), .dm_ack(dm_ack),
        .rom_adr(rom_adr), .rom_dat_w(rom_dat_w), .rom_sel(rom_sel), .rom_we(rom_we),
        .rom_cyc(rom_cyc), .rom_stb(rom_stb), .rom_dat_r(rom_dat_r), .rom_ack(rom_ack),
        .ram_adr(ram_adr), .ram_dat_w(ram_dat_w), .ram_sel(ram_sel), .ram_we(ram_we),
        .ram_cyc(ram_cyc), .ram_stb(ram_stb), .ram_dat_r(ram_dat_r), .ram_ack(ram_ack),
        .per_adr(per_adr), .per_dat_w(per_dat_w), .per_sel(per_sel), .per_we(per_we),
        .per_cyc(per_cyc), .per_stb(per_stb), .per_dat_r(per_dat_r), .per_ack(per_ack)
    );

    function automatic logic [31:0] rom_val(input logic [31:0] a);
        return a ^ 32'h5A00_0000;
    endfunction

    // 0 unmapped, 1 ROM, 2 RAM, 3 peripheral, by plain range comparison.
    function automatic int region(input logic [31:0] a);
        if (a >= ROM_B && a < ROM_B + ROM_S) return 1;
        if (a >= RAM_B && a < RAM_B + RAM_S) return 2;
        if (a >= PER_B && a < PER_B + PER_S) return 3;
        return 0;
    endfunction

    // Slave models: one-cycle registered ack; RAM and peripheral index low address bits only.
    logic [31:0] ram_mem [512];
    logic [31:0] per_mem [64];
    initial begin
        for (int i = 0; i < 512; i++) ram_mem[i] = 32'd0;
        for (int i = 0; i < 64; i++) per_mem[i] = 32'd0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            rom_ack <= 1'b0; ram_ack <= 1'b0; per_ack <= 1'b0;
            rom_dat_r <= 32'd0; ram_dat_r <= 32'd0; per_dat_r <= 32'd0;
        end else begin
            rom_ack   <= rom_cyc & rom_stb & ~rom_ack;
            rom_dat_r <= rom_val(rom_adr);
            ram_ack   <= ram_cyc & ram_stb & ~ram_ack;
            ram_dat_r <= ram_mem[ram_adr[10:2]];
            per_ack   <= per_cyc & per_stb & ~per_ack;
            per_dat_r <= per_mem[per_adr[7:2]];
            if (ram_cyc && ram_stb && !ram_ack && ram_we)
                for (int b = 0; b < 4; b++)
                    if (ram_sel[b]) ram_mem[ram_adr[10:2]][b*8 +: 8] <= ram_dat_w[b*8 +: 8];
            if (per_cyc && per_stb && !per_ack && per_we)
                for (int b = 0; b < 4; b++)
                    if (per_sel[b]) per_mem[per_adr[7:2]][b*8 +: 8] <= per_dat_w[b*8 +: 8];
        end
    end

    // Monitor at the falling edge: reach (R2), forwarding (R3), slave selection (R4).
    always @(negedge clk) begin
        if (rst_n) begin
            if (mc[0] && !mc[1] && (ram_cyc || per_cyc)) mon_r2++;
            if (ram_stb && (ram_dat_w !== mwd[1] || ram_sel !== msel[1] ||
                            ram_we !== mwe[1] || ram_adr !== madr[1])) mon_r3++;
            if (per_stb && (per_dat_w !== mwd[1] || per_sel !== msel[1] ||
                            per_we !== mwe[1] || per_adr !== madr[1])) mon_r3++;
            if (mc[1]) begin
                case (region(madr[1]))
                    2: if (!ram_cyc || per_cyc) mon_r4++;
                    3: if (!per_cyc || ram_cyc) mon_r4++;
                    default: if (ram_cyc || per_cyc) mon_r4++;
                endcase
            end else if (ram_cyc || per_cyc) begin
                mon_r4++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle of n strobes on consecutive words; called at a falling edge.
    // lat counts falling edges from the start to the last ack.
    task automatic run(input int m, input logic [31:0] adr, input logic we,
                       input logic [31:0] wd, input logic [3:0] sel, input int n,
                       output logic [31:0] rd, output int lat);
        int t;
        t = 0; lat = 0; rd = 32'd0;
        mc[m] = 1'b1; ms[m] = 1'b1; madr[m] = adr; mwe[m] = we; mwd[m] = wd; msel[m] = sel;
        for (int k = 0; k < n; k++) begin
            int w;
            w = 0;
            do begin @(negedge clk); t++; w++; end while (!mack[m] && w < 64);
            if (!mack[m]) begin
                errors++; checks++;
                $display("FAIL R5: master %0d hung, actual no ack expected ack", m);
            end
            rd = mrd[m];
            lat = t;
            @(negedge clk); t++;
            madr[m] = adr + 32'(4 * (k + 1));
        end
        mc[m] = 1'b0; ms[m] = 1'b0; mwe[m] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd, rd2, v, a;
        int lat, lat2;
        logic [31:0] bases [6];
        logic [31:0] sizes [6];
        for (int m = 0; m < 2; m++) begin
            mc[m] = 0; ms[m] = 0; mwe[m] = 0; madr[m] = 0; mwd[m] = 0; msel[m] = 0;
        end
        bases = '{ROM_B, RAM_B, PER_B, 32'h0000_0000, 32'h4000_0000, 32'h4000_3000};
        sizes = '{ROM_S, RAM_S, PER_S, 32'h1000, 32'h1000, 32'h100};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset.
        chk("R10 acks", {30'd0, im_ack, dm_ack}, 32'd0);
        chk("R10 slave cyc", {29'd0, rom_cyc, ram_cyc, per_cyc}, 32'd0);

        // Edge sweep: data write then read, then instruction read (R1, R2, R5, R9).
        for (int b = 0; b < 6; b++) begin
            for (int o = 0; o < 4; o++) begin
                logic [31:0] off;
                int rg;
                off = (o == 0) ? 32'd0 : (o == 1) ? 32'd4 : (o == 2) ? sizes[b] - 4 : sizes[b];
                a = bases[b] + off;
                rg = region(a);
                v = a ^ 32'h1357_9BDF;
                run(1, a, 1'b1, v, 4'hF, 1, rd, lat);
                chk(rg == 0 ? "R5 miss write latency" : "R9 write latency", 32'(lat), 32'd1);
                run(1, a, 1'b0, 32'd0, 4'hF, 1, rd, lat);
                chk(rg == 0 ? "R5 miss read zero" : "R1 data read",
                    rd, rg == 1 ? rom_val(a) : (rg == 0 ? 32'd0 : v));
                chk("R9 read latency", 32'(lat), 32'd1);
                run(0, a, 1'b0, 32'd0, 4'hF, 1, rd, lat);
                chk(rg == 1 ? "R1 instr ROM read" : "R2 instr out of reach",
                    rd, rg == 1 ? rom_val(a) : 32'd0);
                chk("R5 instr latency", 32'(lat), 32'd1);
            end
        end
        // R5: writes one past RAM and peripheral windows must not alias onto word 0.
        run(1, RAM_B, 1'b0, 32'd0, 4'hF, 1, rd, lat);
        chk("R5 past-RAM write ignored", rd, RAM_B ^ 32'h1357_9BDF);
        run(1, PER_B, 1'b0, 32'd0, 4'hF, 1, rd, lat);
        chk("R5 past-peripheral write ignored", rd, PER_B ^ 32'h1357_9BDF);

        // R2: instruction writes to RAM and peripheral change nothing.
        run(1, RAM_B + 32'h10, 1'b1, 32'h0BAD_F00D, 4'hF, 1, rd, lat);
        run(1, PER_B + 32'h8, 1'b1, 32'hCAFE_0042, 4'hF, 1, rd, lat);
        run(0, RAM_B + 32'h10, 1'b1, 32'hFFFF_FFFF, 4'hF, 1, rd, lat);
        run(0, PER_B + 32'h8, 1'b1, 32'hFFFF_FFFF, 4'hF, 1, rd, lat);
        run(1, RAM_B + 32'h10, 1'b0, 32'd0, 4'hF, 1, rd, lat);
        chk("R2 RAM untouched by instr", rd, 32'h0BAD_F00D);
        run(1, PER_B + 32'h8, 1'b0, 32'd0, 4'hF, 1, rd, lat);
        chk("R2 peripheral untouched by instr", rd, 32'hCAFE_0042);

        // R3: byte lanes 0 and 2 only.
        run(1, RAM_B + 32'h40, 1'b1, 32'h1122_3344, 4'hF, 1, rd, lat);
        run(1, RAM_B + 32'h40, 1'b1, 32'hAABB_CCDD, 4'b0101, 1, rd, lat);
        run(1, RAM_B + 32'h40, 1'b0, 32'd0, 4'hF, 1, rd, lat);
        chk("R3 byte select merge", rd, 32'h11BB_33DD);
        run(1, PER_B + 32'h4, 1'b1, 32'h0000_0000, 4'hF, 1, rd, lat);
        run(1, PER_B + 32'h4, 1'b1, 32'h9988_7766, 4'b1000, 1, rd, lat);
        run(1, PER_B + 32'h4, 1'b0, 32'd0, 4'hF, 1, rd, lat);
        chk("R3 peripheral top lane", rd, 32'h9900_0000);

        // R6, R8: same-cycle ROM contention, data master first, instruction right after.
        @(negedge clk);
        fork
            begin
                logic [31:0] r; int l;
                run(1, ROM_B + 32'h20, 1'b0, 32'd0, 4'hF, 1, r, l);
                rd2 = r; lat2 = l;
            end
            begin
                logic [31:0] r; int l;
                run(0, ROM_B + 32'h10, 1'b0, 32'd0, 4'hF, 1, r, l);
                rd = r; lat = l;
            end
        join
        chk("R6 data wins latency", 32'(lat2), 32'd1);
        chk("R6 data ROM value", rd2, rom_val(ROM_B + 32'h20));
        chk("R8 instr waits, no idle gap", 32'(lat), 32'd3);
        chk("R8 instr ROM value", rd, rom_val(ROM_B + 32'h10));

        // R7, R8: instruction holds a three-strobe cycle; data arrives one cycle later.
        @(negedge clk);
        fork
            begin
                logic [31:0] r; int l;
                run(0, ROM_B + 32'h100, 1'b0, 32'd0, 4'hF, 3, r, l);
                rd = r; lat = l;
            end
            begin
                logic [31:0] r; int l;
                @(negedge clk);
                run(1, ROM_B + 32'h200, 1'b0, 32'd0, 4'hF, 1, r, l);
                rd2 = r; lat2 = l;
            end
        join
        chk("R7 owner keeps grant over strobes", 32'(lat), 32'd5);
        chk("R7 last burst word", rd, rom_val(ROM_B + 32'h108));
        chk("R8 data waits for release", 32'(lat2), 32'd6);
        chk("R8 data ROM value", rd2, rom_val(ROM_B + 32'h200));

        @(negedge clk);
        chk("R2 monitor: instr never at RAM/peripheral", 32'(mon_r2), 32'd0);
        chk("R3 monitor: forwarded fields", 32'(mon_r3), 32'd0);
        chk("R4 monitor: only selected slave", 32'(mon_r4), 32'd0);
        chk("R10 idle at end", {29'd0, rom_cyc, ram_cyc, per_cyc}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule